// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a two-wire serial slave and gathers the data bytes of one write transfer into a small page latch. The transfer's starting word address is split in two. The upper bits pick a page and stay fixed for the whole transfer. The low bits pick a slot inside that page, and that slot pointer advances after every byte. When it passes the last slot it wraps, so a long transfer overwrites the bytes that arrived earlier.

Nothing reaches the storage array while bytes are being collected. A stop strobe that follows at least one latched byte starts a self-timed write interval of a parameterized number of clocks. In the first clocks of that interval, every slot that received data is copied to the array, one slot per clock. Slots that received nothing keep their old array contents. For the whole interval the busy flag is high and the block ignores its bus-side inputs. A new start condition seen before the stop throws the partial page away.

Top module: `page_commit_buf`

## Requirements
- R1: After reset `busy_o` is 0 and `mem_we_o` is 0.
- R2: A committed byte goes to array address {page, slot}. The page is bits [6:2] of the address loaded with `addr_load_i`. The slot starts at bits [1:0] of that address and advances by one per received byte, wrapping from 3 to 0.
- R3: When more than four bytes arrive before stop, each slot holds the last byte written to it, and that byte is what gets committed.
- R4: `mem_we_o` is never high while `busy_o` is low, so no byte reaches the array before stop.
- R5: A stop that arrives with no byte latched since the last start, address load or commit leaves `busy_o` low and writes nothing.
- R6: A stop with at least one latched byte raises `busy_o` on the next clock. `busy_o` then stays high for exactly `WR_CYCLES` clocks.
- R7: During the first four busy clocks, the slots that received data are written one per clock in ascending slot order. Each such slot is written exactly once. No other write happens in the interval.
- R8: While `busy_o` is high, the start, address, byte and stop strobes have no effect. They neither change the array nor leave data that a later stop would commit.
- R9: A start strobe before stop discards all latched bytes.
- R10: When `busy_o` falls, the slot record is cleared, so a stop with no new byte commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-clock strobe: start condition seen on the bus |
| addr_load_i | input | 1 | One-clock strobe: word address received |
| addr_i | input | 7 | Word address: page in [6:2], first slot in [1:0] |
| byte_vld_i | input | 1 | One-clock strobe: data byte received |
| byte_i | input | 8 | Received data byte |
| stop_i | input | 1 | One-clock strobe: stop condition seen on the bus |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | 7 | Array write address |
| mem_wdata_o | output | 8 | Array write data |
| busy_o | output | 1 | High for the whole self-timed write interval |

## Verification
The hardest case to reach is a strobe that lands inside the write interval. It could corrupt the array or leave a stale slot record behind, and that record would only show itself at a later, empty stop. The stimulus fires random mixes of start, address, byte and stop strobes on every one of the first busy clocks. After busy falls it issues an empty stop and checks that neither busy nor any write follows. Overflowing pages (up to seven bytes from a random first slot) and transfers aborted by a fresh start are mixed into the random sequence, next to directed wrap and empty-stop cases.

// File: rtl/page_commit_buf.sv
module page_commit_buf #(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int SLOT_W    = 2,
  parameter int WR_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              busy_o
);

  localparam int SLOTS  = 1 << SLOT_W;
  localparam int PAGE_W = ADDR_W - SLOT_W;
  localparam int CNT_W  = $clog2(WR_CYCLES + 1);

  logic [DATA_W-1:0] latch_q [SLOTS];
  logic [SLOTS-1:0]  mask_q;
  logic [PAGE_W-1:0] page_q;
  logic [SLOT_W-1:0] ptr_q;
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;

  wire [SLOT_W-1:0] slot_sel = cnt_q[SLOT_W-1:0];
  wire              in_win   = busy_q && (cnt_q < CNT_W'(SLOTS));
  wire              last_cyc = (cnt_q == CNT_W'(WR_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      page_q <= '0;
      ptr_q  <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (last_cyc) begin
        busy_q <= 1'b0;
        mask_q <= '0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (stop_i) begin
      if (|mask_q) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (start_i) begin
      mask_q <= '0;
    end else if (addr_load_i) begin
      mask_q <= '0;
      page_q <= addr_i[ADDR_W-1:SLOT_W];
      ptr_q  <= addr_i[SLOT_W-1:0];
    end else if (byte_vld_i) begin
      mask_q[ptr_q] <= 1'b1;
      ptr_q         <= ptr_q + 1'b1;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!busy_q && !stop_i && !start_i && !addr_load_i && byte_vld_i &&
          ptr_q == SLOT_W'(s))
        latch_q[s] <= byte_i;
    end
  end

  assign mem_we_o    = in_win && mask_q[slot_sel];
  assign mem_addr_o  = {page_q, slot_sel};
  assign mem_wdata_o = latch_q[slot_sel];
  assign busy_o      = busy_q;

endmodule

// File: rtl/page_commit_buf_chk.sv
module page_commit_buf_chk #(
  parameter int ADDR_W    = 7,
  parameter int SLOT_W    = 2,
  parameter int WR_CYCLES = 250000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              busy_o
);

  localparam int SLOTS = 1 << SLOT_W;
  localparam int BC_W  = $clog2(WR_CYCLES + 2);

  logic [BC_W-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bcnt <= '0;
    else if (busy_o) bcnt <= bcnt + 1'b1;
    else             bcnt <= '0;
  end

  AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o); // R4

  AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i)); // R6

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> bcnt == BC_W'(WR_CYCLES)); // R6

  AST_WE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> bcnt < BC_W'(SLOTS)); // R7

  AST_SLOT_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o) && $past(busy_o) && bcnt != '0) |->
      mem_addr_o[SLOT_W-1:0] > $past(mem_addr_o[SLOT_W-1:0])); // R7

  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |->
      $stable(mem_addr_o[ADDR_W-1:SLOT_W])); // R2

endmodule

bind page_commit_buf page_commit_buf_chk #(
  .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .busy_o(busy_o)
);

// File: tb/sim_page_commit_buf.sv
module sim_page_commit_buf;
  localparam int WR = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, addr_load_i = 0, byte_vld_i = 0, stop_i = 0;
  logic [6:0] addr_i = '0;
  logic [7:0] byte_i = '0;
  logic mem_we_o, busy_o;
  logic [6:0] mem_addr_o;
  logic [7:0] mem_wdata_o;

  always #10 clk = ~clk;

  page_commit_buf #(.WR_CYCLES(WR)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_load_i(addr_load_i),
    .addr_i(addr_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i), .stop_i(stop_i),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .busy_o(busy_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_mem [128];
  logic [7:0] obs_mem [128];
  logic [7:0] m_latch [4];
  logic [3:0] m_mask = '0;
  logic [4:0] m_page = '0;
  logic [1:0] m_ptr = '0;
  int busy_len = 0, wr_cnt = 0, order_bad = 0, stray = 0;
  int last_slot = -1;

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int popc(logic [3:0] m);
    return $countones(m);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o) busy_len++;
      if (mem_we_o && !busy_o) stray++;
      if (mem_we_o) begin
        obs_mem[mem_addr_o] = mem_wdata_o;
        if (int'(mem_addr_o[1:0]) <= last_slot) order_bad++;
        if (mem_addr_o[6:2] != m_page) order_bad++;
        last_slot = int'(mem_addr_o[1:0]);
        wr_cnt++;
      end
    end
  end

  task automatic drive(bit st, bit al, logic [6:0] a, bit bv, logic [7:0] b, bit sp);
    @(negedge clk);
    start_i = st; addr_load_i = al; addr_i = a; byte_vld_i = bv; byte_i = b; stop_i = sp;
    @(negedge clk);
    start_i = 0; addr_load_i = 0; byte_vld_i = 0; stop_i = 0;
  endtask

  task automatic send_start();
    drive(1, 0, '0, 0, '0, 0);
    m_mask = '0;
  endtask

  task automatic send_addr(logic [6:0] a);
    drive(0, 1, a, 0, '0, 0);
    m_mask = '0; m_page = a[6:2]; m_ptr = a[1:0];
  endtask

  task automatic send_byte(logic [7:0] d);
    drive(0, 0, '0, 1, d, 0);
    m_latch[m_ptr] = d; m_mask[m_ptr] = 1'b1; m_ptr = m_ptr + 2'd1;
  endtask

  task automatic commit(string tag);
    int n;
    n = popc(m_mask);
    for (int s = 0; s < 4; s++)
      if (m_mask[s]) exp_mem[{m_page, 2'(s)}] = m_latch[s];
    busy_len = 0; wr_cnt = 0; order_bad = 0; last_slot = -1;
    drive(0, 0, '0, 0, '0, 1);
    check(busy_o == (n != 0), (n != 0) ? "R6 busy after stop" : "R5 empty stop", busy_o, n != 0);
    if (n != 0) begin
      for (int j = 0; j < 6; j++)
        drive($urandom_range(0, 1), $urandom_range(0, 1), 7'($urandom),
              $urandom_range(0, 1), 8'($urandom), $urandom_range(0, 1));
      while (busy_o) @(negedge clk);
      check(busy_len == WR, "R6 busy length", busy_len, WR);
      check(wr_cnt == n, {"R7 write count ", tag}, wr_cnt, n);
      check(order_bad == 0, "R7 order and R2 page", order_bad, 0);
      for (int s = 0; s < 4; s++)
        check(obs_mem[{m_page, 2'(s)}] === exp_mem[{m_page, 2'(s)}],
              {"R2 R3 R8 page content ", tag},
              obs_mem[{m_page, 2'(s)}], exp_mem[{m_page, 2'(s)}]);
      m_mask = '0;
      wr_cnt = 0;
      drive(0, 0, '0, 0, '0, 1);
      check(busy_o == 0, "R10 R8 stop after commit", busy_o, 0);
      repeat (5) @(negedge clk);
      check(wr_cnt == 0, "R10 no rewrite", wr_cnt, 0);
    end else begin
      repeat (5) @(negedge clk);
      check(wr_cnt == 0, {"R5 R9 no write ", tag}, wr_cnt, 0);
    end
    check(stray == 0, "R4 write outside busy", stray, 0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual 0 expected 1");
    finish_up();
  end

  initial begin
    int seed;
    seed = $urandom(20240611);
    for (int i = 0; i < 128; i++) begin exp_mem[i] = 8'h00; obs_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    check(busy_o == 0 && mem_we_o == 0, "R1 reset state", {busy_o, mem_we_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 0, "R1 idle after reset", busy_o, 0);

    // single byte write
    send_start(); send_addr(7'h11); send_byte(8'hA5); commit("single");
    // wrap from slot 2 with four bytes
    send_start(); send_addr(7'h2A); send_byte(8'h01); send_byte(8'h02);
    send_byte(8'h03); send_byte(8'h04); commit("wrap");
    // six bytes overwrite slots 1 and 2
    send_start(); send_addr(7'h41);
    for (int k = 0; k < 6; k++) send_byte(8'h10 + 8'(k));
    commit("overflow");
    // address only, acknowledge-poll style
    send_start(); send_addr(7'h7C); commit("empty");
    // abort by new start
    send_start(); send_addr(7'h05); send_byte(8'hEE); send_byte(8'hDD);
    send_start(); commit("abort");
    // top of array, sparse slot
    send_start(); send_addr(7'h7F); send_byte(8'h99); commit("top");

    for (int t = 0; t < 40; t++) begin
      int nb;
      send_start();
      send_addr(7'($urandom));
      nb = $urandom_range(0, 7);
      for (int k = 0; k < nb; k++) send_byte(8'($urandom));
      if ($urandom_range(0, 5) == 0) begin
        send_start();
        if ($urandom_range(0, 1) == 1) begin
          send_addr(7'($urandom));
          for (int k = 0; k < int'($urandom_range(0, 3)); k++) send_byte(8'($urandom));
        end
      end
      commit("random");
    end

    for (int i = 0; i < 128; i++)
      if (obs_mem[i] !== exp_mem[i])
        check(0, "R8 array image", obs_mem[i], exp_mem[i]);
    checks++;
    finish_up();
  end
endmodule